// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block sits on the host side of a bridge and turns the two-port configuration mechanism into routed configuration cycles. Software first writes a 32-bit configuration address word through a dedicated I/O port pair. When it then touches the configuration data window, the block decodes the stored bus, device, function and register fields. It then raises one registered request that names where the cycle must go.

There are four destinations. The bridge's own devices on bus 0 form the first. The second is a Type 0 cycle on the secondary port, where the device number becomes a one-hot select line in the upper address half. The third is a Type 1 cycle on the secondary port for buses behind it. The last is an upstream cycle for everything else. A Type 0 access to a device number that has no select line raises an abort flag, so that the bridge's status logic can record a master abort. I/O accesses the block does not claim are flagged for pass-through to the upstream link as ordinary I/O cycles.

Top module: `cfg_cycle_router`

## Requirements
- R1: After synchronous reset the address word is 00000000h and io_rvalid, pass_valid, cyc_valid and cyc_abort are all 0.
- R2: A write with all four byte enables at port 0CF8h stores bit 31 and bits 23:2 of the data. Bits 30:24 and 1:0 read as zero. A full-width read at 0CF8h returns the word on io_rdata with io_rvalid one cycle after the request.
- R3: A byte or word access (byte enables not 1111b) anywhere in 0CF8h–0CFBh leaves the address word unchanged and raises pass_valid one cycle later, with no io_rvalid.
- R4: An access to the data window 0CFCh–0CFFh while bit 31 is 0, or to any port outside both windows, raises pass_valid and never cyc_valid. pass_valid and cyc_valid are never high together.
- R5: With bus 0 and device 0, 1, 2, 3, 6 or 7 and function 0, a data-window access issues target code 0 (internal) with cyc_addr = {16'h0, device, function, register, 2'b00}.
- R6: With bus 0, one of those internal device numbers and a nonzero function, a data-window access raises neither cyc_valid nor pass_valid.
- R7: With bus 0 and any other device number, the request carries target code 3 (upstream) and cyc_addr = {16'h0, device, function, register, 2'b00}.
- R8: With a nonzero bus equal to sec_bus and device below 16, the request carries target code 1 (secondary Type 0). cyc_addr[31:16] has only bit 16+device set, bits 15:11 are zero and bits 10:0 are {function, register, 2'b00}.
- R9: In the R8 case with a device of 16 or above, cyc_addr[31:16] is all zero and cyc_abort is 1. cyc_abort is 0 for every other request.
- R10: With a nonzero bus above sec_bus and no greater than sub_bus, the request carries target code 2 (secondary Type 1) and cyc_addr = {8'h0, bus, device, function, register, 2'b01}.
- R11: Any other nonzero bus (below sec_bus or above sub_bus) carries target code 3 and the same Type 1 address form as R10.
- R12: A routed request is a one-cycle cyc_valid pulse in the cycle after the data-window access. It carries that access's write flag on cyc_wr and its byte enables on cyc_be.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Host I/O access strobe, one cycle per access |
| io_wr | input | 1 | 1 for write, 0 for read |
| io_port | input | 16 | I/O port address |
| io_be | input | 4 | Byte enables of the access |
| io_wdata | input | 32 | Write data |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| io_rvalid | output | 1 | Read data of the address word is valid |
| io_rdata | output | 32 | Address word read data |
| pass_valid | output | 1 | Access goes upstream as a plain I/O cycle |
| cyc_valid | output | 1 | Routed configuration cycle request |
| cyc_target | output | 2 | 0 internal, 1 secondary Type 0, 2 secondary Type 1, 3 upstream |
| cyc_wr | output | 1 | Direction of the routed cycle |
| cyc_be | output | 4 | Byte enables of the routed cycle |
| cyc_addr | output | 32 | Outgoing cycle address |
| cyc_abort | output | 1 | Type 0 cycle with no select line: master abort |

## Verification
Two decisions land in one cycle here. The bus-number comparison reads sec_bus and sub_bus in the same edge that accepts the data-window access, and an out-of-range Type 0 device must produce both the request and the abort flag together. The vector walk changes sec_bus and sub_bus in the very cycle of each data access, so the target code shows whether the new numbers were used. The vectors for devices 15 and 16 on the secondary bus are judged on target code, select lines and abort flag together in the single result cycle.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 6;

  typedef enum logic [1:0] {
    TGT_INT    = 2'd0,
    TGT_SEC_T0 = 2'd1,
    TGT_SEC_T1 = 2'd2,
    TGT_UP     = 2'd3
  } tgt_e;

  typedef struct packed {
    logic             en;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] rn;
  } cfga_t;
endpackage

// File: rtl/cfgr_addr_reg.sv
module cfgr_addr_reg
  import cfgr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output cfga_t       fields,
  output logic [31:0] word
);
  localparam int LOW_W = DEV_W + FN_W + REG_W;

  cfga_t held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (wr_en) begin
      held.en  <= wdata[31];
      held.bus <= wdata[16 +: BUS_W];
      held.dev <= wdata[11 +: DEV_W];
      held.fn  <= wdata[8 +: FN_W];
      held.rn  <= wdata[2 +: REG_W];
    end
  end

  assign fields = held;
  assign word   = {held.en, {(31 - BUS_W - LOW_W - 2){1'b0}}, held.bus,
                   held.dev, held.fn, held.rn, 2'b00};

  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (word[31] == $past(wdata[31])) && (word[23:2] == $past(wdata[23:2])));
endmodule

// File: rtl/cfgr_idsel.sv
module cfgr_idsel #(
  parameter int LINES = 16,
  parameter int DEV_W = 5
) (
  input  logic [DEV_W-1:0] dev,
  output logic [LINES-1:0] sel,
  output logic             miss
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign sel[i] = (dev == DEV_W'(i));
  end
  assign miss = ~|sel;
endmodule

// File: rtl/cfgr_route.sv
module cfgr_route
  import cfgr_pkg::*;
#(
  parameter logic [31:0] INT_DEV_MASK = 32'h0000_00CF
) (
  input  cfga_t            a,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output tgt_e             tgt,
  output logic             issue,
  output logic             abort,
  output logic [31:0]      addr
);
  localparam int LOW_W = DEV_W + FN_W + REG_W + 2;
  localparam int HI_W  = 32 - LOW_W;
  localparam int PAD_W = HI_W - BUS_W;

  logic            bus_zero, is_int;
  logic [HI_W-1:0] sel;
  logic            miss;

  cfgr_idsel #(.LINES(HI_W), .DEV_W(DEV_W)) u_idsel (
    .dev  (a.dev),
    .sel  (sel),
    .miss (miss)
  );

  assign bus_zero = (a.bus == '0);
  assign is_int   = bus_zero && INT_DEV_MASK[a.dev];

  always_comb begin
    if (bus_zero)
      tgt = is_int ? TGT_INT : TGT_UP;
    else if (a.bus == sec_bus)
      tgt = TGT_SEC_T0;
    else if ((a.bus > sec_bus) && (a.bus <= sub_bus))
      tgt = TGT_SEC_T1;
    else
      tgt = TGT_UP;
  end

  assign issue = !(is_int && (a.fn != '0));
  assign abort = (tgt == TGT_SEC_T0) && miss;

  always_comb begin
    if (tgt == TGT_SEC_T0)
      addr = {sel, {DEV_W{1'b0}}, a.fn, a.rn, 2'b00};
    else if (bus_zero)
      addr = {{HI_W{1'b0}}, a.dev, a.fn, a.rn, 2'b00};
    else
      addr = {{PAD_W{1'b0}}, a.bus, a.dev, a.fn, a.rn, 2'b01};
  end
endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
  import cfgr_pkg::*;
#(
  parameter int          IO_AW        = 16,
  parameter logic [15:0] ADDR_PORT    = 16'h0CF8,
  parameter logic [15:0] DATA_PORT    = 16'h0CFC,
  parameter logic [31:0] INT_DEV_MASK = 32'h0000_00CF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_req,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_port,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  input  logic [7:0]       sec_bus,
  input  logic [7:0]       sub_bus,
  output logic             io_rvalid,
  output logic [31:0]      io_rdata,
  output logic             pass_valid,
  output logic             cyc_valid,
  output logic [1:0]       cyc_target,
  output logic             cyc_wr,
  output logic [3:0]       cyc_be,
  output logic [31:0]      cyc_addr,
  output logic             cyc_abort
);
  localparam int HI_LO = DEV_W + FN_W + REG_W + 2;

  cfga_t       fields;
  logic [31:0] word;
  tgt_e        r_tgt;
  logic        r_issue, r_abort;
  logic [31:0] r_addr;
  logic        in_aw, in_dw, claim_a, cfg_hit, pass_now;

  assign in_aw    = (io_port[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
  assign in_dw    = (io_port[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);
  assign claim_a  = io_req && in_aw && (io_be == 4'hF) && (io_port[1:0] == 2'b00);
  assign cfg_hit  = io_req && in_dw && fields.en;
  assign pass_now = io_req && !claim_a && !cfg_hit;

  cfgr_addr_reg u_areg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (claim_a && io_wr),
    .wdata  (io_wdata),
    .fields (fields),
    .word   (word)
  );

  cfgr_route #(.INT_DEV_MASK(INT_DEV_MASK)) u_route (
    .a       (fields),
    .sec_bus (sec_bus),
    .sub_bus (sub_bus),
    .tgt     (r_tgt),
    .issue   (r_issue),
    .abort   (r_abort),
    .addr    (r_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid  <= 1'b0;
      io_rdata   <= '0;
      pass_valid <= 1'b0;
      cyc_valid  <= 1'b0;
      cyc_target <= '0;
      cyc_wr     <= 1'b0;
      cyc_be     <= '0;
      cyc_addr   <= '0;
      cyc_abort  <= 1'b0;
    end else begin
      io_rvalid  <= claim_a && !io_wr;
      if (claim_a && !io_wr) io_rdata <= word;
      pass_valid <= pass_now;
      cyc_valid  <= cfg_hit && r_issue;
      cyc_abort  <= cfg_hit && r_issue && r_abort;
      if (cfg_hit) begin
        cyc_target <= r_tgt;
        cyc_wr     <= io_wr;
        cyc_be     <= io_be;
        cyc_addr   <= r_addr;
      end
    end
  end

  a_r12_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |-> $past(io_req));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cyc_valid && pass_valid));
  a_r9_abort_t0_only: assert property (@(posedge clk) disable iff (rst)
    cyc_abort |-> (cyc_valid && (cyc_target == TGT_SEC_T0) && (cyc_addr[31:HI_LO] == '0)));
  a_r8_single_idsel: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && (cyc_target == TGT_SEC_T0) && !cyc_abort) |->
      ($countones(cyc_addr[31:HI_LO]) == 1));
  a_r10_type1_tag: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && (cyc_target == TGT_SEC_T1)) |-> (cyc_addr[1:0] == 2'b01));
endmodule

// File: tb/cfg_cycle_router_bench.sv
`timescale 1ns/1ps
module cfg_cycle_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_port = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic [7:0]  sec_bus = '0, sub_bus = '0;
  logic        io_rvalid, pass_valid, cyc_valid, cyc_wr, cyc_abort;
  logic [31:0] io_rdata, cyc_addr;
  logic [1:0]  cyc_target;
  logic [3:0]  cyc_be;
  int applied = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  cfg_cycle_router u_cfg_cycle_router (
    .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_port(io_port),
    .io_be(io_be), .io_wdata(io_wdata), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .io_rvalid(io_rvalid), .io_rdata(io_rdata), .pass_valid(pass_valid),
    .cyc_valid(cyc_valid), .cyc_target(cyc_target), .cyc_wr(cyc_wr),
    .cyc_be(cyc_be), .cyc_addr(cyc_addr), .cyc_abort(cyc_abort)
  );

  typedef struct packed {
    logic [31:0] ca;
    logic [7:0]  sec;
    logic [7:0]  sub;
    logic        v;
    logic [1:0]  tgt;
    logic [31:0] addr;
    logic        ab;
    logic        ps;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h8000_0010, 8'd2, 8'd5, 1'b1, 2'd0, 32'h0000_0010, 1'b0, 1'b0, 8'd5},  // R5
    '{32'h8000_38FC, 8'd2, 8'd5, 1'b1, 2'd0, 32'h0000_38FC, 1'b0, 1'b0, 8'd5},  // R5
    '{32'h8000_3204, 8'd2, 8'd5, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 1'b0, 8'd6},  // R6
    '{32'h8000_2108, 8'd2, 8'd5, 1'b1, 2'd3, 32'h0000_2108, 1'b0, 1'b0, 8'd7},  // R7
    '{32'h8000_FFFC, 8'd2, 8'd5, 1'b1, 2'd3, 32'h0000_FFFC, 1'b0, 1'b0, 8'd7},  // R7
    '{32'h8002_0004, 8'd2, 8'd5, 1'b1, 2'd1, 32'h0001_0004, 1'b0, 1'b0, 8'd8},  // R8
    '{32'h8002_7B14, 8'd2, 8'd5, 1'b1, 2'd1, 32'h8000_0314, 1'b0, 1'b0, 8'd8},  // R8
    '{32'h8002_8000, 8'd2, 8'd5, 1'b1, 2'd1, 32'h0000_0000, 1'b1, 1'b0, 8'd9},  // R9
    '{32'h8003_0904, 8'd2, 8'd5, 1'b1, 2'd2, 32'h0003_0905, 1'b0, 1'b0, 8'd10}, // R10
    '{32'h8005_1000, 8'd2, 8'd5, 1'b1, 2'd2, 32'h0005_1001, 1'b0, 1'b0, 8'd10}, // R10
    '{32'h8006_1000, 8'd2, 8'd5, 1'b1, 2'd3, 32'h0006_1001, 1'b0, 1'b0, 8'd11}, // R11
    '{32'h8001_1000, 8'd2, 8'd5, 1'b1, 2'd3, 32'h0001_1001, 1'b0, 1'b0, 8'd11}, // R11
    '{32'h0002_0004, 8'd2, 8'd5, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 1'b1, 8'd4},  // R4
    '{32'h8009_1800, 8'd9, 8'd9, 1'b1, 2'd1, 32'h0008_0000, 1'b0, 1'b0, 8'd8}   // R8
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the result visible.
  task automatic access(input logic [15:0] p, input logic w, input logic [3:0] be, input logic [31:0] d);
    io_port = p; io_wr = w; io_be = be; io_wdata = d; io_req = 1'b1;
    @(negedge clk);
    io_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({io_rvalid, pass_valid, cyc_valid, cyc_abort} == 4'b0, "R1 outputs",
        {io_rvalid, pass_valid, cyc_valid, cyc_abort}, 0);
    access(16'h0CF8, 1'b0, 4'hF, 0);
    chk(io_rvalid && io_rdata == 32'h0, "R1 reset word", {io_rvalid, io_rdata}, {1'b1, 32'h0});

    // R2 reserved bits drop out
    access(16'h0CF8, 1'b1, 4'hF, 32'hFFFF_FFFF);
    access(16'h0CF8, 1'b0, 4'hF, 0);
    chk(io_rvalid && io_rdata == 32'h80FF_FFFC, "R2 readback", {io_rvalid, io_rdata}, {1'b1, 32'h80FF_FFFC});

    // R3 byte write is passed through and leaves the word alone
    access(16'h0CF9, 1'b1, 4'b0010, 32'h0);
    chk(pass_valid && !cyc_valid && !io_rvalid, "R3 byte pass", {pass_valid, cyc_valid, io_rvalid}, 3'b100);
    access(16'h0CFA, 1'b0, 4'b1100, 32'h0);
    chk(pass_valid && !io_rvalid, "R3 word read pass", {pass_valid, io_rvalid}, 2'b10);
    access(16'h0CF8, 1'b0, 4'hF, 0);
    chk(io_rdata == 32'h80FF_FFFC, "R3 word unchanged", io_rdata, 32'h80FF_FFFC);

    // R4 unrelated port
    access(16'h0080, 1'b1, 4'hF, 32'h1);
    chk(pass_valid && !cyc_valid, "R4 other port", {pass_valid, cyc_valid}, 2'b10);

    // R12 write data access carries direction and enables, one-cycle pulse
    access(16'h0CF8, 1'b1, 4'hF, 32'h8000_0004);
    access(16'h0CFE, 1'b1, 4'b1100, 32'h1234_5678);
    chk(cyc_valid && cyc_wr && cyc_be == 4'b1100 && cyc_target == 2'd0 && cyc_addr == 32'h4,
        "R12 write cycle", {cyc_valid, cyc_wr, cyc_be, cyc_target, cyc_addr},
        {1'b1, 1'b1, 4'b1100, 2'd0, 32'h4});
    @(negedge clk);
    chk(!cyc_valid, "R12 pulse width", cyc_valid, 0);

    // Vector walk: bus numbers change in the same cycle as the data access
    for (int i = 0; i < NV; i++) begin
      access(16'h0CF8, 1'b1, 4'hF, VECS[i].ca);
      sec_bus = VECS[i].sec; sub_bus = VECS[i].sub;
      access(16'h0CFC, 1'b0, 4'hF, 0);
      if (VECS[i].v)
        chk(cyc_valid && cyc_target == VECS[i].tgt && cyc_addr == VECS[i].addr &&
            cyc_abort == VECS[i].ab && !pass_valid && !cyc_wr && cyc_be == 4'hF,
            $sformatf("R%0d vec %0d", VECS[i].rq, i),
            {cyc_valid, cyc_target, cyc_addr, cyc_abort, pass_valid},
            {1'b1, VECS[i].tgt, VECS[i].addr, VECS[i].ab, 1'b0});
      else
        chk(!cyc_valid && !cyc_abort && pass_valid == VECS[i].ps,
            $sformatf("R%0d vec %0d", VECS[i].rq, i),
            {cyc_valid, cyc_abort, pass_valid}, {1'b0, 1'b0, VECS[i].ps});
    end

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule